// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block produces an interrupt request at a rate chosen by software. A free-running divider in the video clock domain turns a 25 MHz clock into a 1 MHz tick. The tick is carried into the CPU clock domain, where it advances a counter. When the counter reaches a terminal value that software has written, a compare output goes high for one tick period and the counter wraps to zero on the following tick. The interrupt output is a single CPU-cycle pulse on each rising edge of that compare.

Software sets the period with a single word-wide write to one I/O address. The same write clears the counter, so every write restarts the period from zero. A terminal value of zero keeps the compare high for good, which gives one interrupt at the moment of the write and none after it. The terminal value cannot be read back.

Top module: `ptimer_top`

## Requirements
- R1: After reset the counter and the terminal value are both 0, `irq_match` is 1, and `irq` stays 0 until software writes a terminal value.
- R2: The counter advances by exactly one per tick, and a tick occurs once every DIV_MOD cycles of `vid_clk`. With terminal value N, `irq` pulses every (N+1)*DIV_MOD cycles of `vid_clk`.
- R3: When the counter equals a nonzero terminal value, `irq_match` is 1 for exactly one tick period, and the next tick returns the counter to 0.
- R4: `irq` is 1 for exactly one `cpu_clk` cycle, in the first cycle in which `irq_match` is 1 after having been 0.
- R5: A write with `io_wr`=1, `io_word`=1 and `io_addr` equal to PORT_ADDR loads `io_wdata` as the terminal value and clears the counter to 0 at the same clock edge, whatever the counter held.
- R6: A write with `io_word`=0 (byte width) leaves both the terminal value and the counter unchanged.
- R7: A write to any address other than PORT_ADDR, or with `io_wr`=0, leaves both the terminal value and the counter unchanged.
- R8: Writing terminal value 0 while the counter differs from the old terminal value gives exactly one `irq` pulse, in the cycle after the write, and no further pulses; `irq_match` then stays 1. Writing 0 while the counter already equals the terminal value (for instance both 0) gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | CPU-side clock; counter, register and interrupt logic |
| vid_clk | input | 1 | Video clock (25 MHz) feeding the tick divider |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| io_wr | input | 1 | I/O write strobe, valid for one `cpu_clk` cycle |
| io_word | input | 1 | 1 = word-wide access, 0 = byte access |
| io_addr | input | ADDR_W (16) | I/O port address |
| io_wdata | input | CNT_W (16) | Write data, the new terminal value |
| irq | output | 1 | Interrupt request, one-cycle pulse |
| irq_match | output | 1 | Level compare: counter equals terminal value |

## Verification
Any fault in the counter, the terminal register or the tick path shows up as a wrong spacing between `irq` pulses, so the bench measures gaps in `cpu_clk` cycles against exact values derived from DIV_MOD and the two clock periods. A missing counter clear on write moves the next pulse by whole ticks and is visible within one programmed period; a lost or doubled tick in the crossing shifts the gap by 50 cycles on the first period after it. A wrong edge register shows up at the write of a zero terminal value, where the pulse must appear in the very next cycle or not at all.

// File: rtl/ptimer_pkg.sv
`timescale 1ns / 1ps
package ptimer_pkg;

   // Form of the interrupt output.
   typedef enum logic {
      IRQ_LEVEL = 1'b0,   // irq follows the compare
      IRQ_EDGE  = 1'b1    // irq is a one-cycle pulse on the compare's rise
   } irq_style_e;

   // Width needed to hold values 0 .. n-1, at least one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ptimer_tickgen.sv
`timescale 1ns / 1ps
module ptimer_tickgen #(
   parameter int unsigned DIV_MOD = 25
) (
   input  logic vid_clk,
   input  logic rst_n,
   output logic tick_pulse
);
   localparam int unsigned DIV_W = ptimer_pkg::idx_width(DIV_MOD);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_MOD - 1);

   logic [DIV_W-1:0] div_q;
   logic             at_last;

   assign at_last = (div_q == DIV_LAST);

   // Modulo-DIV_MOD count; the pulse is registered so the crossing sees a clean edge.
   always_ff @(posedge vid_clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q      <= '0;
         tick_pulse <= 1'b0;
      end else begin
         div_q      <= at_last ? '0 : div_q + 1'b1;
         tick_pulse <= at_last;
      end
   end
endmodule

// File: rtl/ptimer_tick_sync.sv
`timescale 1ns / 1ps
module ptimer_tick_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic tick
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= async_in;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_in};
         end
      end
   endgenerate

   // Rising edge of the synchronized level gives one tick per divider period.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign tick = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ptimer_core.sv
`timescale 1ns / 1ps
module ptimer_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] term_q,
   output logic             match
);
   assign match = (cnt_q == term_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         term_q <= '0;
      end else if (load) begin
         term_q <= load_val;
         cnt_q  <= '0;
      end else if (tick) begin
         cnt_q  <= match ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ptimer_top.sv
`timescale 1ns / 1ps
module ptimer_top #(
   parameter int unsigned             CNT_W       = 16,
   parameter int unsigned             ADDR_W      = 16,
   parameter int unsigned             PORT_ADDR   = 32'h0070,
   parameter int unsigned             DIV_MOD     = 25,
   parameter int unsigned             SYNC_STAGES = 2,
   parameter ptimer_pkg::irq_style_e  IRQ_STYLE   = ptimer_pkg::IRQ_EDGE
) (
   input  logic              cpu_clk,
   input  logic              vid_clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              io_word,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [CNT_W-1:0]  io_wdata,
   output logic              irq,
   output logic              irq_match
);
   localparam logic [ADDR_W-1:0] PORT_SEL = ADDR_W'(PORT_ADDR);

   // Elaboration-time parameter checks.
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("ptimer_top: CNT_W must be at least 1");
      end
      if (DIV_MOD < 2) begin : g_bad_div
         $error("ptimer_top: DIV_MOD must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ptimer_top: SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 32 && (PORT_ADDR >> ADDR_W) != 0) begin : g_bad_addr
         $error("ptimer_top: PORT_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   logic             tick_pulse_v;
   logic             tick_cpu;
   logic             wr_hit;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term_q;
   logic             match;

   assign wr_hit = io_wr & io_word & (io_addr == PORT_SEL);

   ptimer_tickgen #(.DIV_MOD(DIV_MOD)) u_div (
      .vid_clk    (vid_clk),
      .rst_n      (rst_n),
      .tick_pulse (tick_pulse_v)
   );

   ptimer_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (cpu_clk),
      .rst_n    (rst_n),
      .async_in (tick_pulse_v),
      .tick     (tick_cpu)
   );

   ptimer_core #(.CNT_W(CNT_W)) u_core (
      .clk      (cpu_clk),
      .rst_n    (rst_n),
      .load     (wr_hit),
      .load_val (io_wdata),
      .tick     (tick_cpu),
      .cnt_q    (cnt_q),
      .term_q   (term_q),
      .match    (match)
   );

   assign irq_match = match;

   generate
      if (IRQ_STYLE == ptimer_pkg::IRQ_EDGE) begin : g_edge
         logic match_q;
         // Reset to 1: counter and terminal both start at 0, so no pulse out of reset.
         always_ff @(posedge cpu_clk or negedge rst_n) begin
            if (!rst_n) match_q <= 1'b1;
            else        match_q <= match;
         end
         assign irq = match & ~match_q;
      end else begin : g_level
         assign irq = match;
      end
   endgenerate
endmodule

// File: rtl/ptimer_chk.sv
`timescale 1ns / 1ps
module ptimer_chk #(
   parameter int unsigned CNT_W = 16,
   parameter bit          EDGE  = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_hit,
   input logic             io_wr,
   input logic             io_word,
   input logic [CNT_W-1:0] io_wdata,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] term,
   input logic             irq,
   input logic             irq_match
);
   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_hit) |=> $stable(cnt)); // R2

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_hit && cnt != term) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_hit && cnt == term) |=> (cnt == '0)); // R3

   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (cnt == '0 && term == $past(io_wdata))); // R5

   AST_BYTE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_word) |=> $stable(term)); // R6

   AST_TERM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(term)); // R7

   AST_PULSE_IN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_match); // R4

   generate
      if (EDGE) begin : g_edge_checks
         AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            irq |=> !irq); // R4

         AST_ZERO_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && io_wdata == '0 && cnt != term) |=> irq); // R8
      end
   endgenerate
endmodule

bind ptimer_top ptimer_chk #(
   .CNT_W (CNT_W),
   .EDGE  (IRQ_STYLE == ptimer_pkg::IRQ_EDGE)
) u_chk (
   .clk       (cpu_clk),
   .rst_n     (rst_n),
   .wr_hit    (wr_hit),
   .io_wr     (io_wr),
   .io_word   (io_word),
   .io_wdata  (io_wdata),
   .tick      (tick_cpu),
   .cnt       (cnt_q),
   .term      (term_q),
   .irq       (irq),
   .irq_match (irq_match)
);

// File: tb/sim_ptimer_top.sv
`timescale 1ns / 1ps
module sim_ptimer_top;
   localparam int unsigned DIV_MOD  = 25;
   localparam logic [15:0] PORT     = 16'h0070;
   // 25 MHz video clock against 50 MHz CPU clock: two CPU cycles per video cycle.
   localparam int          TICK_CYC = DIV_MOD * 2;

   logic        clk = 1'b0;
   logic        vclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic        io_word = 1'b0;
   logic [15:0] io_addr = '0;
   logic [15:0] io_wdata = '0;
   logic        irq;
   logic        irq_match;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;
   initial begin
      #5;
      forever #20 vclk = ~vclk;
   end

   ptimer_top #(.DIV_MOD(DIV_MOD), .PORT_ADDR(32'h0070)) u0 (
      .cpu_clk   (clk),
      .vid_clk   (vclk),
      .rst_n     (rst_n),
      .io_wr     (io_wr),
      .io_word   (io_word),
      .io_addr   (io_addr),
      .io_wdata  (io_wdata),
      .irq       (irq),
      .irq_match (irq_match)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] a, input bit word, input logic [15:0] d);
      io_addr  = a;
      io_word  = word;
      io_wdata = d;
      io_wr    = 1'b1;
      @(negedge clk);
      io_wr    = 1'b0;
      io_word  = 1'b0;
   endtask

   // Advances negedge by negedge until irq is seen or limit is reached.
   task automatic wait_pulse(input int limit, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!irq && n < limit);
   endtask

   task automatic t_reset();
      int n;
      chk(irq_match === 1'b1, "R1 match after reset", int'(irq_match), 1);
      chk(irq === 1'b0, "R1 irq after reset", int'(irq), 0);
      wait_pulse(300, n);
      chk(!irq, "R1 no pulse before first write", int'(irq), 0);
   endtask

   task automatic t_period();
      int n;
      int m;
      do_write(PORT, 1'b1, 16'd3);
      chk(irq_match === 1'b0, "R5 match low after load", int'(irq_match), 0);
      wait_pulse(1000, n);
      chk(irq === 1'b1, "R2 first pulse", int'(irq), 1);
      m = 1;
      @(negedge clk);
      chk(irq === 1'b0, "R4 pulse width one cycle", int'(irq), 0);
      while (irq_match && m < 1000) begin
         m++;
         @(negedge clk);
      end
      chk(m == TICK_CYC, "R3 match lasts one tick", m, TICK_CYC);
      wait_pulse(1000, n);
      chk(irq && (m + n) == 4 * TICK_CYC, "R2 period term 3", m + n, 4 * TICK_CYC);
   endtask

   task automatic t_byte();
      int n;
      do_write(PORT, 1'b0, 16'd1);
      wait_pulse(1000, n);
      chk(irq && (1 + n) == 4 * TICK_CYC, "R6 byte write ignored", 1 + n, 4 * TICK_CYC);
   endtask

   task automatic t_addr();
      int n;
      do_write(PORT + 16'd1, 1'b1, 16'd1);
      io_addr  = PORT;
      io_word  = 1'b1;
      io_wdata = 16'd1;
      @(negedge clk);
      io_word  = 1'b0;
      wait_pulse(1000, n);
      chk(irq && (2 + n) == 4 * TICK_CYC, "R7 foreign address and idle strobe ignored",
          2 + n, 4 * TICK_CYC);
   endtask

   task automatic t_restart();
      int n;
      // At a pulse the counter holds 3; after 110 cycles it holds 1.
      repeat (110) @(negedge clk);
      do_write(PORT, 1'b1, 16'd10);
      wait_pulse(2000, n);
      chk(irq && (111 + n) == 12 * TICK_CYC, "R5 write restarts count",
          111 + n, 12 * TICK_CYC);
   endtask

   task automatic t_zero();
      int n;
      repeat (110) @(negedge clk);
      do_write(PORT, 1'b1, 16'd0);
      chk(irq === 1'b1, "R8 one-shot pulse after zero write", int'(irq), 1);
      wait_pulse(300, n);
      chk(!irq, "R8 no repeat pulse", int'(irq), 0);
      chk(irq_match === 1'b1, "R8 match stays high", int'(irq_match), 1);
      do_write(PORT, 1'b1, 16'd0);
      chk(irq === 1'b0, "R8 zero write with count already zero", int'(irq), 0);
      wait_pulse(300, n);
      chk(!irq, "R8 still no pulse", int'(irq), 0);
   endtask

   task automatic t_term1();
      int n;
      do_write(PORT, 1'b1, 16'd1);
      wait_pulse(1000, n);
      chk(irq === 1'b1, "R2 first pulse term 1", int'(irq), 1);
      wait_pulse(1000, n);
      chk(irq && n == 2 * TICK_CYC, "R2 period term 1", n, 2 * TICK_CYC);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_period();
      t_byte();
      t_addr();
      t_restart();
      t_zero();
      t_term1();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R2 act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule